// File: doc/BRIEF.md
# Host Parallel Byte Port

This block lets an external microprocessor move a stream of bytes (for example MIDI traffic) into and out of the device over an 8-bit parallel bus. The host drives active-low chip select, write and read strobes and a single address bit, all of them asynchronous to the device clock. With the address bit at 0 the host reaches the data register: a write sends one byte inward and a read fetches one byte outward. With the address bit at 1 a read returns a status byte and a write goes to a control byte. A board-level pull-down on the address pin is expected, so that an undriven pin selects the data register.

On the core side the block has two single-byte channels with valid/ready handshakes. Bytes written by the host come out of an inbound channel, and bytes offered by the core enter through an outbound channel. An active-high interrupt tells the host that an outbound byte is waiting. The interrupt stays up until the host reads the data register. A host write that arrives while the inbound register is still occupied is dropped and recorded in a sticky overrun flag, which the host clears through the control byte.

All host pins pass through a two-stage synchronizer. Each access takes effect once, on the rising (deasserting) edge of its strobe, and only if chip select was low. The bus driver is modelled as a registered data output plus an output enable.

Top module: `host_byte_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `irq`, `in_valid` and `bus_oe` are 0 and `out_ready` is 1. A status read straight after reset returns 0x00.
- R2: A host write with the address bit at 0 to an empty inbound register takes effect on the rising edge of the write strobe, within 4 clock cycles of that edge. After it, `in_valid` is 1 and `in_data` holds the byte. While the strobe is still low, `in_valid` stays 0.
- R3: A host write with the address bit at 0 while `in_valid` is 1 is dropped: `in_data` does not change, and status bit 2 (overrun) becomes 1 and stays 1.
- R4: `in_valid` and `in_data` hold until a cycle with `in_ready` high. After that cycle `in_valid` is 0, status bit 1 (inbound busy) is 0, and the host can write a new byte.
- R5: When `out_ready` is 1, a cycle with `out_valid` high loads `out_data`. After that cycle `irq` is 1 and `out_ready` is 0. While `out_ready` is 0, `out_valid` has no effect.
- R6: A host read with the address bit at 0 returns the held outbound byte on `bus_dout`. On the rising edge of the read strobe it clears `irq` and sets `out_ready` to 1.
- R7: A host read with the address bit at 1 returns the status byte: bit 0 is outbound byte waiting, bit 1 is inbound busy, bit 2 is overrun, and bits 7..3 are 0. Such a read leaves `irq` unchanged.
- R8: A host write with the address bit at 1 goes to the control byte. Bit 0 set to 1 clears the overrun flag. The other bits have no effect, and the write does not change the inbound register or `in_valid`.
- R9: Strobes given while chip select is high have no effect on either data register or on `irq`.
- R10: `bus_oe` is 1 only while chip select and read are both low, delayed by the synchronizer. It returns to 0 after the read strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Host chip select, active low, asynchronous |
| bus_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_addr | input | 1 | Register select: 0 data, 1 status (read) / control (write) |
| bus_din | input | 8 | Byte driven by the host during a write |
| bus_dout | output | 8 | Byte returned to the host during a read |
| bus_oe | output | 1 | Output enable for the host data bus driver |
| irq | output | 1 | Interrupt, high while an outbound byte waits |
| in_data | output | 8 | Inbound byte toward the core |
| in_valid | output | 1 | Inbound byte present |
| in_ready | input | 1 | Core takes the inbound byte |
| out_data | input | 8 | Outbound byte from the core |
| out_valid | input | 1 | Core offers an outbound byte |
| out_ready | output | 1 | Outbound register is empty |

## Verification
A pin change made just after a clock edge reaches the second synchronizer stage two edges later. The strobe edge is detected in the cycle after that, and the register or flag updates on the third edge. The registered read data and output enable also follow a falling read strobe on the third edge. The bench drives the pins on falling clock edges and holds every strobe level for at least four cycles. It samples flags and data four or five falling edges after a change, so each result is read after it is due and before the next stimulus. Core-side handshakes take effect on the next edge, and the bench samples them one falling edge later.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned SYNC_DEPTH  = 2;
  // status byte bit positions
  localparam int unsigned ST_OUT_BIT  = 0;
  localparam int unsigned ST_BUSY_BIT = 1;
  localparam int unsigned ST_OVR_BIT  = 2;
  // control byte bit positions
  localparam int unsigned CT_CLR_BIT  = 0;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hbp_strobe.sv
module hbp_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic wr_s,
  input  logic rd_s,
  output logic wr_pulse,
  output logic rd_pulse,
  output logic rd_active
);
  logic cs_q, wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      cs_q <= cs_s;
      wr_q <= wr_s;
      rd_q <= rd_s;
    end
  end

  // rising strobe edge, with chip select low in the cycle before
  assign wr_pulse  = wr_s && !wr_q && !cs_q;
  assign rd_pulse  = rd_s && !rd_q && !cs_q;
  assign rd_active = !cs_s && !rd_s;
endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
  import hbp_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_pulse,
  input  logic          rd_pulse,
  input  logic          rd_active,
  input  logic          addr_s,
  input  logic [DW-1:0] din_s,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          irq,
  output logic [DW-1:0] in_data,
  output logic          in_valid,
  input  logic          in_ready,
  input  logic [DW-1:0] out_data,
  input  logic          out_valid,
  output logic          out_ready
);
  logic [DW-1:0] in_reg, out_reg, status;
  logic          in_full, out_full, ovr;

  always_comb begin
    status              = '0;
    status[ST_OUT_BIT]  = out_full;
    status[ST_BUSY_BIT] = in_full;
    status[ST_OVR_BIT]  = ovr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg   <= '0;
      in_full  <= 1'b0;
      ovr      <= 1'b0;
      out_reg  <= '0;
      out_full <= 1'b0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      // inbound: core take, then host write judged on the old busy flag
      if (in_full && in_ready) in_full <= 1'b0;
      if (wr_pulse && !addr_s) begin
        if (in_full) ovr <= 1'b1;
        else begin
          in_reg  <= din_s;
          in_full <= 1'b1;
        end
      end
      if (wr_pulse && addr_s && din_s[CT_CLR_BIT]) ovr <= 1'b0;
      // outbound: host read empties, core push fills only when empty
      if (rd_pulse && !addr_s) out_full <= 1'b0;
      if (!out_full && out_valid) begin
        out_reg  <= out_data;
        out_full <= 1'b1;
      end
      // host bus driver
      bus_oe <= rd_active;
      if (rd_active) bus_dout <= addr_s ? status : out_reg;
    end
  end

  assign irq       = out_full;
  assign out_ready = !out_full;
  assign in_valid  = in_full;
  assign in_data   = in_reg;
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
  import hbp_pkg::*;
#(
  parameter int unsigned DW     = BYTE_W,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic          bus_rd_n,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          irq,
  output logic [DW-1:0] in_data,
  output logic          in_valid,
  input  logic          in_ready,
  input  logic [DW-1:0] out_data,
  input  logic          out_valid,
  output logic          out_ready
);
  localparam int unsigned PAYLOAD_W = DW + 1;

  logic          cs_s, wr_s, rd_s, addr_s;
  logic [DW-1:0] din_s;
  logic          wr_pulse, rd_pulse, rd_active;

  hbp_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync_ctl (
    .clk (clk),
    .rst (rst),
    .d   ({bus_cs_n, bus_wr_n, bus_rd_n}),
    .q   ({cs_s, wr_s, rd_s})
  );

  hbp_sync #(.W(PAYLOAD_W), .STAGES(STAGES), .RST_VAL('0)) u_sync_dat (
    .clk (clk),
    .rst (rst),
    .d   ({bus_addr, bus_din}),
    .q   ({addr_s, din_s})
  );

  hbp_strobe u_strobe (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (cs_s),
    .wr_s      (wr_s),
    .rd_s      (rd_s),
    .wr_pulse  (wr_pulse),
    .rd_pulse  (rd_pulse),
    .rd_active (rd_active)
  );

  hbp_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_pulse  (wr_pulse),
    .rd_pulse  (rd_pulse),
    .rd_active (rd_active),
    .addr_s    (addr_s),
    .din_s     (din_s),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .irq       (irq),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_oe,
  input logic          irq,
  input logic [DW-1:0] in_data,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          rd_pulse,
  input logic          addr_s
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && !in_valid && out_ready && !bus_oe)); // R1

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data))); // R3

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(out_valid && out_ready)); // R5

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(rd_pulse && !addr_s)); // R6

  AST_OE_GATED: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!bus_cs_n && !bus_rd_n, 3)); // R10
endmodule

bind host_byte_port hbp_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_oe    (bus_oe),
  .irq       (irq),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .rd_pulse  (rd_pulse),
  .addr_s    (addr_s)
);

// File: tb/tb_host_byte_port.sv
module tb_host_byte_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_addr = 1'b0;
  logic [7:0] bus_din = '0, bus_dout;
  logic       bus_oe, irq, in_valid, out_ready;
  logic [7:0] in_data;
  logic       in_ready = 1'b0, out_valid = 1'b0;
  logic [7:0] out_data = '0;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  host_byte_port dut (
    .clk(clk), .rst(rst),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .irq(irq), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // host write; cs_sel=0 keeps chip select low, 1 leaves it high
  task automatic host_write(input logic a, input logic [7:0] d, input logic cs_off,
                            output logic mid_valid);
    @(negedge clk);
    bus_cs_n = cs_off; bus_addr = a; bus_din = d;
    wait_n(2);
    bus_wr_n = 1'b0;
    wait_n(5);
    mid_valid = in_valid;
    bus_wr_n = 1'b1;
    wait_n(4);
    bus_cs_n = 1'b1;
    wait_n(4);
  endtask

  task automatic host_read(input logic a, input logic cs_off,
                           output logic [7:0] d, output logic oe_seen);
    @(negedge clk);
    bus_cs_n = cs_off; bus_addr = a;
    wait_n(2);
    bus_rd_n = 1'b0;
    wait_n(5);
    d = bus_dout; oe_seen = bus_oe;
    bus_rd_n = 1'b1;
    wait_n(4);
    bus_cs_n = 1'b1;
    wait_n(4);
  endtask

  task automatic core_push(input logic [7:0] d);
    @(negedge clk);
    out_data = d; out_valid = 1'b1;
    @(negedge clk);
    out_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic core_take;
    @(negedge clk);
    in_ready = 1'b1;
    @(negedge clk);
    in_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 in_valid", {7'b0, in_valid}, 8'h00);
    chk("R1 out_ready", {7'b0, out_ready}, 8'h01);
    chk("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
    host_read(1'b1, 1'b0, d, oe);
    chk("R1 status after reset", d, 8'h00);
    chk("R10 oe during read", {7'b0, oe}, 8'h01);
    chk("R10 oe after read", {7'b0, bus_oe}, 8'h00);
  endtask

  task automatic t_write;
    logic mid; logic [7:0] d; logic oe;
    host_write(1'b0, 8'h5A, 1'b0, mid);
    chk("R2 no effect while strobe low", {7'b0, mid}, 8'h00);
    chk("R2 in_valid", {7'b0, in_valid}, 8'h01);
    chk("R2 in_data", in_data, 8'h5A);
    host_read(1'b1, 1'b0, d, oe);
    chk("R7 status busy", d, 8'h02);
  endtask

  task automatic t_overrun;
    logic mid; logic [7:0] d; logic oe;
    host_write(1'b0, 8'hC3, 1'b0, mid);
    chk("R3 in_data kept", in_data, 8'h5A);
    host_read(1'b1, 1'b0, d, oe);
    chk("R3 overrun set", d, 8'h06);
    host_write(1'b1, 8'hFE, 1'b0, mid);
    host_read(1'b1, 1'b0, d, oe);
    chk("R8 bit0 clear leaves overrun", d, 8'h06);
    host_write(1'b1, 8'h01, 1'b0, mid);
    host_read(1'b1, 1'b0, d, oe);
    chk("R8 overrun cleared", d, 8'h02);
    chk("R8 in_data untouched", in_data, 8'h5A);
    chk("R8 in_valid untouched", {7'b0, in_valid}, 8'h01);
  endtask

  task automatic t_take;
    logic mid; logic [7:0] d; logic oe;
    wait_n(3);
    chk("R4 held without ready", in_data, 8'h5A);
    core_take();
    chk("R4 in_valid cleared", {7'b0, in_valid}, 8'h00);
    host_read(1'b1, 1'b0, d, oe);
    chk("R4 status idle", d, 8'h00);
    host_write(1'b0, 8'h11, 1'b0, mid);
    chk("R4 new byte accepted", in_data, 8'h11);
    core_take();
  endtask

  task automatic t_outbound;
    logic [7:0] d; logic oe;
    core_push(8'hA7);
    chk("R5 irq set", {7'b0, irq}, 8'h01);
    chk("R5 out_ready low", {7'b0, out_ready}, 8'h00);
    core_push(8'h33);
    host_read(1'b1, 1'b0, d, oe);
    chk("R7 status outbound", d, 8'h01);
    chk("R7 status read keeps irq", {7'b0, irq}, 8'h01);
    host_read(1'b0, 1'b0, d, oe);
    chk("R6 data read byte (R5 push while full ignored)", d, 8'hA7);
    chk("R6 irq cleared", {7'b0, irq}, 8'h00);
    chk("R6 out_ready back", {7'b0, out_ready}, 8'h01);
  endtask

  task automatic t_deselected;
    logic mid; logic [7:0] d; logic oe;
    host_write(1'b0, 8'h77, 1'b1, mid);
    chk("R9 write while deselected", {7'b0, in_valid}, 8'h00);
    core_push(8'h44);
    host_read(1'b0, 1'b1, d, oe);
    chk("R10 no oe while deselected", {7'b0, oe}, 8'h00);
    chk("R9 read while deselected keeps irq", {7'b0, irq}, 8'h01);
    host_read(1'b0, 1'b0, d, oe);
    chk("R6 second byte", d, 8'h44);
    chk("R6 irq cleared again", {7'b0, irq}, 8'h00);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        vectors++; fails++;
        $display("FAIL watchdog (all R): actual %0d cycles expected fewer than 20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_overrun();
    t_take();
    t_outbound();
    t_deselected();
    finish_run();
  end
endmodule